// File: doc/BRIEF.md
# Programmable Sample-Strobe Edge Detector

This block produces the strobe that times sampling in a sampled-data front end. Everything runs on the master clock. In the plain mode, an external strobe input already carries a pulse one master-clock period wide at the sample rate, and that pulse is passed straight on to the sampling logic.

In detect mode, the strobe input may carry any periodic waveform at the sample rate, such as the shift clock of a sensor. The block synchronises that waveform and finds the chosen edge of it. For each such edge it emits a one-cycle internal pulse, which can be pushed later by a programmed number of clocks. A selector picks either this internal pulse or the raw external strobe as the active strobe. A one-cycle sample-enable fires on the first clock edge after the active strobe has gone low again.

The control inputs are static configuration bits. A change to them applies only to edges detected after the change. Pulses already waiting out their delay keep the timing they had when their edge was detected.

Top module: `strobe_edge_gen`

## Requirements
- R1: With detEnable = 0, selStrobe equals strobeIn combinationally, in the same cycle.
- R2: With detEnable = 1, selStrobe equals intPulse, so strobeIn held high with no pending pulse leaves selStrobe low.
- R3: With risingSel = 1, every low-to-high transition of strobeIn yields exactly one intPulse of one cycle, and high-to-low transitions yield none.
- R4: With risingSel = 0, every high-to-low transition of strobeIn yields exactly one intPulse of one cycle, and low-to-high transitions yield none.
- R5: delaySel is an unsigned binary count of 0 to 7 clocks. If strobeIn first shows its new level at rising clock edge n, intPulse is high from edge n+2+delaySel until edge n+3+delaySel.
- R6: Pulses waiting out their delay are all kept. Detected edges only two clocks apart with delaySel = 7 each produce their own pulse at the R5 time.
- R7: sampleEn is high for exactly one cycle, starting at the first rising edge that samples selStrobe low after it was sampled high. A selStrobe high in the cycle before edge m therefore gives sampleEn from edge m+1.
- R8: A synchronous active-high rst clears all state. intPulse and sampleEn are low in the cycle after reset. No pulse comes from edges seen before reset, and none comes from the level strobeIn holds when reset is released.
- R9: Changing delaySel or risingSel leaves edges already detected unaffected. Such a pulse appears with the delay that was set when its edge was registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| detEnable | input | 1 | 1 selects the internal pulse, 0 the raw strobe |
| risingSel | input | 1 | 1 detects rising edges, 0 falling edges |
| delaySel | input | 3 | Extra delay of the internal pulse in clocks |
| strobeIn | input | 1 | External strobe or periodic reference waveform |
| intPulse | output | 1 | Internal one-cycle pulse, visible for test |
| selStrobe | output | 1 | Active strobe after the source selector |
| sampleEn | output | 1 | One-cycle sample enable |

## Verification
A corrupted synchroniser, edge register or delay slot shows up at intPulse as a pulse at the wrong time, as a missing pulse, or as an extra pulse. Two cycles later the same fault shows up again as a misplaced sampleEn. The scoreboard predicts the exact cycle of every pulse from the R5 formula, so a one-cycle shift is caught at the first affected edge. Back-to-back edges at the longest delay expose dropped pulses in flight. Control changes made mid-flight, and a reset issued while the input is held high, expose state that was not isolated or not cleared.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int unsigned DELAY_BITS = 3;
  localparam int unsigned MAX_DELAY  = (1 << DELAY_BITS) - 1;

  typedef logic [DELAY_BITS-1:0] delay_t;

  // Registered edge event handed from control to datapath
  typedef struct packed {
    logic   edgeHit;
    delay_t edgeDelay;
  } edgeCmd_t;
endpackage

// File: rtl/strobe_edge_ctrl.sv
module strobe_edge_ctrl
  import strobe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     strobeIn,
  input  logic     risingSel,
  input  delay_t   delaySel,
  output edgeCmd_t cmd
);
  localparam int unsigned WARM_LIMIT = SYNC_STAGES + 1;
  localparam int unsigned WARM_BITS  = $clog2(WARM_LIMIT + 1);
  typedef logic [WARM_BITS-1:0] warm_t;

  logic [SYNC_STAGES-1:0] syncQ;
  logic  syncLvl;
  logic  lastLvl;
  warm_t warmCnt;
  logic  primed;
  logic  edgeSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '0;
    end else begin
      syncQ[0] <= strobeIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  assign syncLvl = syncQ[SYNC_STAGES-1];

  // Edges are trusted only once both compared samples are post-reset values
  always_ff @(posedge clk) begin
    if (rst) begin
      lastLvl <= 1'b0;
      warmCnt <= '0;
    end else begin
      lastLvl <= syncLvl;
      if (warmCnt != warm_t'(WARM_LIMIT)) warmCnt <= warmCnt + warm_t'(1);
    end
  end

  assign primed = (warmCnt == warm_t'(WARM_LIMIT));

  always_comb begin
    if (risingSel) edgeSeen = primed && syncLvl && !lastLvl;
    else           edgeSeen = primed && !syncLvl && lastLvl;
  end

  // The delay travels with the edge so later control changes cannot alter it
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0;
    end else begin
      cmd.edgeHit   <= edgeSeen;
      cmd.edgeDelay <= delaySel;
    end
  end
endmodule

// File: rtl/strobe_edge_path.sv
module strobe_edge_path
  import strobe_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  edgeCmd_t cmd,
  input  logic     detEnable,
  input  logic     strobeIn,
  output logic     intPulse,
  output logic     selStrobe,
  output logic     sampleEn
);
  logic [SLOTS-1:0] slotBusy;
  logic [SLOTS-1:0] slotFire;
  logic [SLOTS-1:0] slotGrant;
  delay_t           slotCnt [SLOTS];
  logic             needSlot;
  logic             directFire;
  logic             stbQ;

  assign needSlot   = cmd.edgeHit && (cmd.edgeDelay != delay_t'(0));
  assign directFire = cmd.edgeHit && (cmd.edgeDelay == delay_t'(0));

  for (genvar g = 0; g < SLOTS; g++) begin : g_fire
    assign slotFire[g] = slotBusy[g] && (slotCnt[g] == delay_t'(1));
  end

  // First free slot (or one releasing this cycle) takes the new edge
  always_comb begin
    logic taken;
    taken     = 1'b0;
    slotGrant = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (needSlot && !taken && (!slotBusy[i] || slotFire[i])) begin
        slotGrant[i] = 1'b1;
        taken        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slotBusy <= '0;
      for (int i = 0; i < SLOTS; i++) slotCnt[i] <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (slotGrant[i]) begin
          slotBusy[i] <= 1'b1;
          slotCnt[i]  <= cmd.edgeDelay;
        end else if (slotFire[i]) begin
          slotBusy[i] <= 1'b0;
        end else if (slotBusy[i]) begin
          slotCnt[i]  <= slotCnt[i] - delay_t'(1);
        end
      end
    end
  end

  assign intPulse  = directFire || (|slotFire);
  assign selStrobe = detEnable ? intPulse : strobeIn;

  // Sample enable on the first edge that sees the active strobe low again
  always_ff @(posedge clk) begin
    if (rst) begin
      stbQ     <= 1'b0;
      sampleEn <= 1'b0;
    end else begin
      stbQ     <= selStrobe;
      sampleEn <= stbQ && !selStrobe;
    end
  end
endmodule

// File: rtl/strobe_edge_gen.sv
module strobe_edge_gen
  import strobe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   detEnable,
  input  logic   risingSel,
  input  delay_t delaySel,
  input  logic   strobeIn,
  output logic   intPulse,
  output logic   selStrobe,
  output logic   sampleEn
);
  // Detected edges are at least two clocks apart, so half the delay span suffices
  localparam int unsigned SLOTS = (MAX_DELAY + 2) / 2;

  edgeCmd_t cmd;

  strobe_edge_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .strobeIn  (strobeIn),
    .risingSel (risingSel),
    .delaySel  (delaySel),
    .cmd       (cmd)
  );

  strobe_edge_path #(.SLOTS(SLOTS)) u_path (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .detEnable (detEnable),
    .strobeIn  (strobeIn),
    .intPulse  (intPulse),
    .selStrobe (selStrobe),
    .sampleEn  (sampleEn)
  );
endmodule

// File: rtl/strobe_edge_gen_chk.sv
module strobe_edge_gen_chk
  import strobe_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   risingSel,
  input delay_t delaySel,
  input logic   strobeIn,
  input logic   intPulse,
  input logic   selStrobe,
  input logic   sampleEn
);
  p_sample_single_r7: assert property (@(posedge clk) disable iff (rst)
    sampleEn |=> !sampleEn);

  p_sample_after_fall_r7: assert property (@(posedge clk) disable iff (rst)
    sampleEn |-> ($past(selStrobe, 2) && !$past(selStrobe, 1)));

  p_rise_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) && !$past(rst, 4) &&
     $past(risingSel, 1) && ($past(delaySel, 1) == delay_t'(0)) &&
     $past(strobeIn, 3) && !$past(strobeIn, 4)) |-> intPulse);

  p_fall_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) && !$past(rst, 4) &&
     !$past(risingSel, 1) && ($past(delaySel, 1) == delay_t'(0)) &&
     !$past(strobeIn, 3) && $past(strobeIn, 4)) |-> intPulse);

  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!intPulse && !sampleEn));
endmodule

bind strobe_edge_gen strobe_edge_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .risingSel (risingSel),
  .delaySel  (delaySel),
  .strobeIn  (strobeIn),
  .intPulse  (intPulse),
  .selStrobe (selStrobe),
  .sampleEn  (sampleEn)
);

// File: tb/test_strobe_edge_gen.sv
`timescale 1ns/1ps
module test_strobe_edge_gen;
  import strobe_pkg::*;

  logic   clk = 1'b0;
  logic   rst = 1'b1;
  logic   detEnable = 1'b0;
  logic   risingSel = 1'b1;
  delay_t delaySel = '0;
  logic   strobeIn = 1'b0;
  logic   intPulse, selStrobe, sampleEn;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    monOn = 1'b0;
  int    pulseQ[$];
  string pulseTag[$];
  int    sampleQ[$];
  string sampleTag[$];

  strobe_edge_gen i_strobe_edge_gen (
    .clk(clk), .rst(rst), .detEnable(detEnable), .risingSel(risingSel),
    .delaySel(delaySel), .strobeIn(strobeIn), .intPulse(intPulse),
    .selStrobe(selStrobe), .sampleEn(sampleEn)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic addExp(ref int q[$], ref string t[$], input int when, input string tag);
    int idx;
    idx = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i] > when) begin idx = i; break; end
    end
    q.insert(idx, when);
    t.insert(idx, tag);
  endtask

  // Driver: change the strobe level at a falling edge and predict results
  task automatic setLevel(input logic v, input string tag);
    int c;
    bit hit;
    c = cyc;
    if (v !== strobeIn) begin
      hit = (v && risingSel) || (!v && !risingSel);
      if (hit) begin
        addExp(pulseQ, pulseTag, c + 3 + int'(delaySel), tag);
        if (detEnable) addExp(sampleQ, sampleTag, c + 5 + int'(delaySel), {"R7 ", tag});
      end
      if (!detEnable && !v) addExp(sampleQ, sampleTag, c + 1, {"R7 ", tag});
    end
    strobeIn = v;
    @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop expected events and compare
  always @(negedge clk) begin
    if (monOn) begin
      if (pulseQ.size() > 0 && pulseQ[0] == cyc) begin
        chk(intPulse == 1'b1, pulseTag[0], int'(intPulse), 1);
        void'(pulseQ.pop_front());
        void'(pulseTag.pop_front());
      end else if (intPulse) begin
        chk(1'b0, "R3/R4 unexpected intPulse", 1, 0);
      end
      if (sampleQ.size() > 0 && sampleQ[0] == cyc) begin
        chk(sampleEn == 1'b1, sampleTag[0], int'(sampleEn), 1);
        void'(sampleQ.pop_front());
        void'(sampleTag.pop_front());
      end else if (sampleEn) begin
        chk(1'b0, "R7 unexpected sampleEn", 1, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    bit seen;
    // R8: reset state
    tick(4);
    chk(!intPulse && !sampleEn && !selStrobe, "R8 reset outputs", int'({intPulse, sampleEn, selStrobe}), 0);
    rst = 1'b0;
    monOn = 1'b1;
    tick(6);

    // R1: raw strobe path, widths 1 and 3
    detEnable = 1'b0;
    risingSel = 1'b1;
    delaySel  = 3'd2;
    for (int w = 1; w <= 3; w += 2) begin
      strobeIn = 1'b0;
      setLevel(1'b1, "R3 ext rise");
      chk(selStrobe == 1'b1, "R1 selStrobe follows strobeIn high", int'(selStrobe), 1);
      tick(w - 1);
      setLevel(1'b0, "R1 ext fall");
      #1 chk(selStrobe == 1'b0, "R1 selStrobe follows strobeIn low", int'(selStrobe), 0);
      tick(14);
    end

    // R3/R5/R2: rising detect at every delay
    detEnable = 1'b1;
    risingSel = 1'b1;
    for (int d = 0; d <= 7; d++) begin
      delaySel = delay_t'(d);
      setLevel(1'b1, $sformatf("R5 rise delay %0d", d));
      #1 chk(selStrobe == 1'b0 && strobeIn == 1'b1, "R2 selStrobe ignores held strobeIn", int'(selStrobe), 0);
      tick(5);
      setLevel(1'b0, "R3 fall ignored");
      tick(14);
    end

    // R4/R5: falling detect at every delay
    risingSel = 1'b0;
    for (int d = 0; d <= 7; d++) begin
      delaySel = delay_t'(d);
      setLevel(1'b1, "R4 rise ignored");
      tick(5);
      setLevel(1'b0, $sformatf("R4 fall delay %0d", d));
      tick(14);
    end

    // R6: edges every two clocks, then every four, at the longest delay
    risingSel = 1'b1;
    delaySel  = 3'd7;
    for (int k = 0; k < 10; k++) begin
      setLevel(1'b1, $sformatf("R6 dense edge %0d", k));
      setLevel(1'b0, "R6 dense low");
    end
    for (int k = 0; k < 5; k++) begin
      setLevel(1'b1, $sformatf("R6 period4 edge %0d", k));
      tick(1);
      setLevel(1'b0, "R6 period4 low");
      tick(1);
    end
    tick(20);

    // R9: delay change while an edge is in flight
    delaySel = 3'd7;
    setLevel(1'b1, "R9 old delay kept");
    tick(3);
    delaySel = 3'd0;
    setLevel(1'b0, "R9 fall ignored");
    setLevel(1'b1, "R9 new delay used");
    tick(20);

    // R9: polarity change applies to later edges only
    risingSel = 1'b0;
    delaySel  = 3'd3;
    tick(6);
    setLevel(1'b0, "R9 new polarity fall");
    tick(6);
    setLevel(1'b1, "R9 rise ignored after change");
    tick(20);

    // R8: reset mid-flight with strobeIn held high
    strobeIn  = 1'b0;
    risingSel = 1'b1;
    delaySel  = 3'd7;
    tick(6);
    strobeIn = 1'b1;
    tick(2);
    monOn = 1'b0;
    rst = 1'b1;
    tick(2);
    pulseQ.delete(); pulseTag.delete(); sampleQ.delete(); sampleTag.delete();
    rst = 1'b0;
    #1 chk(!intPulse && !sampleEn, "R8 quiet after reset", int'({intPulse, sampleEn}), 0);
    monOn = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (intPulse || sampleEn) seen = 1'b1;
    end
    chk(!seen, "R8 no pulse from held level or old edge", int'(seen), 0);
    setLevel(1'b0, "R8 fall ignored");
    tick(2);
    setLevel(1'b1, "R8 edge after reset");
    tick(25);

    chk(pulseQ.size() == 0, "R5 all pulses seen", pulseQ.size(), 0);
    chk(sampleQ.size() == 0, "R7 all enables seen", sampleQ.size(), 0);
    finishRun();
  end
endmodule